// File: doc/BRIEF.md
# Lookup-Table Colour Mapper for Passive-Matrix Panels

This block turns a low-depth pixel index into three 6-bit colour components. The colour levels come from three small lookup registers rather than a palette RAM. The red and green registers are 32 bits wide and hold eight 4-bit levels each. The blue register is 16 bits wide and holds four 4-bit levels. A mode input picks one of two ways to read them:

- **Direct mode** (1, 2 and 4 bits per pixel): the index picks the same slot in all three registers.
- **Packed mode** (8 bits per pixel): the index is split into fields of 3, 3 and 2 bits, one field per channel.

The selected 4-bit level is widened to six bits. Software loads the lookup registers through a single-cycle write port.

The same block also works out the line geometry. It takes a pixel-depth code and the raw height and width fields of the panel set-up. From these it gives the number of lines and the number of bytes one line occupies in memory.

Top module: `stn_lut_mapper`

## Requirements
- R1: After reset all three lookup registers are zero, so every index in either mode gives 0 on all three colour outputs.
- R2: A write with `wr_en` high loads the register chosen by `wr_sel`:
  - 0 loads red from `wr_data[31:0]`.
  - 1 loads green from `wr_data[31:0]`.
  - 2 loads blue from `wr_data[15:0]`.
  - 3 changes nothing.
  - The new contents show on the outputs from the cycle after the write edge, not in the cycle the write is presented.
- R3: With `packed_mode` = 1, red uses slot `pix_idx[7:5]`, green uses slot `pix_idx[4:2]` and blue uses slot `pix_idx[1:0]`. Slot k of a register is bits [4k+3:4k].
- R4: With `packed_mode` = 0, an index i below 4 uses slot i of all three registers, and an index i below 8 uses slot i of red and green.
- R5: Each colour output equals the selected 4-bit level shifted left by two, so its two low bits are always zero.
- R6: With `packed_mode` = 0, an index above 7 gives 0 on red and green, and an index above 3 gives 0 on blue.
- R7: `line_count` equals `height_fld` + 1, and `height_fld` = 1023 gives 1024.
- R8: With width W = `width_fld` + 1, `line_bytes` depends on `depth_code` as follows:
  - 0 (1 bpp) gives W/8.
  - 1 (2 bpp) gives W/4.
  - 2 (4 bpp) gives W/2.
  - 3 (8 bpp) gives W.
  - 4 (12 bpp) gives 3W/2.
  - 5 (16 bpp) gives 2W.
  - 6 (24 bpp) gives 4W.
  - Every division rounds down.
- R9: A `depth_code` of 7 to 15 gives `line_bytes` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Lookup register write strobe |
| wr_sel | input | 2 | Target register: 0 red, 1 green, 2 blue, 3 none |
| wr_data | input | 32 | Write data |
| packed_mode | input | 1 | 1 selects packed 8-bpp mode, 0 selects direct mode |
| pix_idx | input | 8 | Pixel index |
| red_o | output | 6 | Red component |
| grn_o | output | 6 | Green component |
| blu_o | output | 6 | Blue component |
| depth_code | input | 4 | Pixel-depth code |
| height_fld | input | HW (10) | Raw height field |
| width_fld | input | WW (11) | Raw width field |
| line_count | output | HW+1 (11) | Number of lines |
| line_bytes | output | WW+3 (14) | Bytes per line |

## Verification
A register write and a lookup can happen in the same cycle. The bench provokes this by presenting a write to red together with an index that reads the slot being written. It first judges that the output still shows the old level before the clock edge. It then judges that the output shows the new level one cycle later. A write with `wr_sel` = 3 is issued under the same conditions, and every output is then read back to confirm that nothing changed.

// File: rtl/stn_lut_mapper.sv
module stn_lut_mapper #(
  parameter int HW = 10,
  parameter int WW = 11,
  parameter int BW = WW + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [31:0]   wr_data,
  input  logic          packed_mode,
  input  logic [7:0]    pix_idx,
  output logic [5:0]    red_o,
  output logic [5:0]    grn_o,
  output logic [5:0]    blu_o,
  input  logic [3:0]    depth_code,
  input  logic [HW-1:0] height_fld,
  input  logic [WW-1:0] width_fld,
  output logic [HW:0]   line_count,
  output logic [BW-1:0] line_bytes
);

  logic [31:0] lut_r, lut_g;
  logic [15:0] lut_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lut_r <= '0;
      lut_g <= '0;
      lut_b <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        2'd0: lut_r <= wr_data;
        2'd1: lut_g <= wr_data;
        2'd2: lut_b <= wr_data[15:0];
        default: ;
      endcase
    end
  end

  logic [2:0] r_sel, g_sel;
  logic [1:0] b_sel;
  logic       rg_ok, b_ok;

  assign r_sel = packed_mode ? pix_idx[7:5] : pix_idx[2:0];
  assign g_sel = packed_mode ? pix_idx[4:2] : pix_idx[2:0];
  assign b_sel = pix_idx[1:0];
  assign rg_ok = packed_mode | (pix_idx[7:3] == 5'd0);
  assign b_ok  = packed_mode | (pix_idx[7:2] == 6'd0);

  assign red_o = rg_ok ? {lut_r[{r_sel, 2'b00} +: 4], 2'b00} : 6'd0;
  assign grn_o = rg_ok ? {lut_g[{g_sel, 2'b00} +: 4], 2'b00} : 6'd0;
  assign blu_o = b_ok  ? {lut_b[{b_sel, 2'b00} +: 4], 2'b00} : 6'd0;

  logic [BW-1:0] wpx;
  assign wpx        = BW'(width_fld) + BW'(1);
  assign line_count = (HW+1)'(height_fld) + (HW+1)'(1);

  always_comb begin
    case (depth_code)
      4'd0:    line_bytes = wpx >> 3;
      4'd1:    line_bytes = wpx >> 2;
      4'd2:    line_bytes = wpx >> 1;
      4'd3:    line_bytes = wpx;
      4'd4:    line_bytes = (wpx + (wpx << 1)) >> 1;
      4'd5:    line_bytes = wpx << 1;
      4'd6:    line_bytes = wpx << 2;
      default: line_bytes = '0;
    endcase
  end

endmodule

// File: rtl/stn_lut_mapper_chk.sv
module stn_lut_mapper_chk #(
  parameter int BW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    wr_sel,
  input logic [31:0]   wr_data,
  input logic          packed_mode,
  input logic [7:0]    pix_idx,
  input logic [5:0]    red_o,
  input logic [5:0]    blu_o,
  input logic [3:0]    depth_code,
  input logic [BW-1:0] line_bytes,
  input logic [31:0]   lut_r,
  input logic [31:0]   lut_g,
  input logic [15:0]   lut_b
);

  assert_red_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!packed_mode && pix_idx > 8'd7) |-> red_o == 6'd0);

  assert_blue_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!packed_mode && pix_idx > 8'd3) |-> blu_o == 6'd0);

  assert_null_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd3) |=> ($stable(lut_r) && $stable(lut_g) && $stable(lut_b)));

  assert_red_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0) |=> lut_r == $past(wr_data));

  assert_bad_depth_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (depth_code > 4'd6) |-> line_bytes == '0);

endmodule

bind stn_lut_mapper stn_lut_mapper_chk #(.BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .packed_mode(packed_mode), .pix_idx(pix_idx), .red_o(red_o), .blu_o(blu_o),
  .depth_code(depth_code), .line_bytes(line_bytes),
  .lut_r(lut_r), .lut_g(lut_g), .lut_b(lut_b)
);

// File: tb/sim_stn_lut_mapper.sv
module sim_stn_lut_mapper;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic packed_mode = 1'b0;
  logic [7:0] pix_idx = '0;
  logic [5:0] red_o, grn_o, blu_o;
  logic [3:0] depth_code = '0;
  logic [9:0] height_fld = '0;
  logic [10:0] width_fld = '0;
  logic [10:0] line_count;
  logic [13:0] line_bytes;

  always #2 clk = ~clk;

  stn_lut_mapper u0 (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] m_r = '0, m_g = '0;
  logic [15:0] m_b = '0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int nib(logic [31:0] v, int k);
    return int'((v >> (4 * k)) & 32'hF);
  endfunction

  task automatic look(string tag, logic pm, logic [7:0] ix);
    int er, eg, eb;
    @(negedge clk);
    packed_mode = pm; pix_idx = ix;
    #1;
    if (pm) begin
      er = nib(m_r, int'(ix[7:5])) * 4;
      eg = nib(m_g, int'(ix[4:2])) * 4;
      eb = nib({16'd0, m_b}, int'(ix[1:0])) * 4;
    end else begin
      er = (ix < 8) ? nib(m_r, int'(ix)) * 4 : 0;
      eg = (ix < 8) ? nib(m_g, int'(ix)) * 4 : 0;
      eb = (ix < 4) ? nib({16'd0, m_b}, int'(ix)) * 4 : 0;
    end
    chk({tag, " red"}, int'(red_o), er);
    chk({tag, " green"}, int'(grn_o), eg);
    chk({tag, " blue"}, int'(blu_o), eb);
  endtask

  task automatic wr(logic [1:0] s, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (s)
      2'd0: m_r = d;
      2'd1: m_g = d;
      2'd2: m_b = d[15:0];
      default: ;
    endcase
  endtask

  task automatic geo(int code, int wf, int exp);
    @(negedge clk);
    depth_code = 4'(code); width_fld = 11'(wf);
    #1;
    chk(code > 6 ? "R9 bytes" : "R8 bytes", int'(line_bytes), exp);
  endtask

  localparam logic [8:0] VEC [16] = '{
    {1'b0, 8'd0}, {1'b0, 8'd1}, {1'b0, 8'd2}, {1'b0, 8'd3},
    {1'b0, 8'd4}, {1'b0, 8'd5}, {1'b0, 8'd6}, {1'b0, 8'd7},
    {1'b0, 8'd8}, {1'b0, 8'd15}, {1'b1, 8'h00}, {1'b1, 8'hFF},
    {1'b1, 8'hA5}, {1'b1, 8'h3C}, {1'b1, 8'h5A}, {1'b1, 8'hC3}
  };

  initial begin
    repeat (3) @(negedge clk);
    look("R1 reset", 1'b0, 8'd2);
    look("R1 reset", 1'b1, 8'hB7);
    rst_n = 1'b1;
    wr(2'd0, 32'h8C3F_A519);
    wr(2'd1, 32'h27E4_0DB6);
    wr(2'd2, 32'hFFFF_5A3C);
    for (int i = 0; i < 16; i++)
      look(VEC[i][8] ? "R3 R5 packed" : "R4 R6 direct", VEC[i][8], VEC[i][7:0]);

    // R2: write and lookup in the same cycle
    @(negedge clk);
    packed_mode = 1'b0; pix_idx = 8'd1;
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 32'h0000_00E0;
    #1;
    chk("R2 old before edge", int'(red_o), nib(m_r, 1) * 4);
    @(negedge clk);
    wr_en = 1'b0; m_r = 32'h0000_00E0;
    #1;
    chk("R2 new after edge", int'(red_o), 14 * 4);
    wr(2'd3, 32'h1234_5678);
    for (int i = 0; i < 4; i++) look("R2 null select", 1'b0, 8'(i));
    look("R2 null select", 1'b1, 8'hFF);

    @(negedge clk);
    height_fld = 10'd319; #1; chk("R7 lines", int'(line_count), 320);
    @(negedge clk);
    height_fld = 10'd1023; #1; chk("R7 lines", int'(line_count), 1024);
    geo(0, 239, 30); geo(1, 239, 60); geo(2, 239, 120); geo(3, 239, 240);
    geo(4, 239, 360); geo(5, 239, 480); geo(6, 239, 960);
    geo(6, 2047, 8192); geo(0, 0, 0); geo(4, 0, 1);
    geo(7, 239, 0); geo(15, 2047, 0);

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    m_r = '0; m_g = '0; m_b = '0;
    look("R1 after reset", 1'b1, 8'h24);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule